// File: doc/BRIEF.md
# Three-Frame Temporal Dither Modulator

This block turns the 4-bit colour code of each pixel into one on/off drive bit for the red sub-pixel and one for the green sub-pixel, once for every panel refresh. Each sub-pixel has a 2-bit intensity level. Level 0 keeps the sub-pixel dark and level 3 keeps it lit. The two middle levels are made over time: a cycle of three refresh frames lights the sub-pixel in one frame out of three, or in two frames out of three. The 16 codes therefore give 16 red/green hue combinations, from black to full yellow.

The refresh scan logic sends one frame tick per internal refresh and then presents each stored pixel with its row and column. The dither phase follows that internal refresh only and has no tie to the rate at which incoming video arrives. The phase used for a pixel is shifted by (row + column) mod 3. At the half-tone levels this spreads the lit frames across the screen, so neighbouring pixels do not all flash in the same frame.

Top module: `tdither_mod`

## Requirements
- R1: After reset, `out_valid`, `red_on` and `green_on` are 0 and the frame phase is 0. A pixel at row 0, column 0 with code 4'b0101, presented before any tick, comes out with both drive bits at 1.
- R2: `out_valid` is 1 in exactly the cycle after a cycle with `pix_valid` = 1. Each result belongs to the pixel presented one cycle earlier, and the results come out in the order the pixels went in. While `out_valid` is 0, `red_on` and `green_on` are 0.
- R3: `pix_code[3:2]` is the red level and `pix_code[1:0]` is the green level. Level 2'b00 gives a drive bit of 0 and level 2'b11 gives a drive bit of 1, whatever the phase is.
- R4: Level 2'b01 gives a drive bit of 1 only when the effective phase is 0.
- R5: Level 2'b10 gives a drive bit of 1 when the effective phase is 0 or 1, and 0 when it is 2.
- R6: The frame phase steps 0→1→2→0 on each cycle with `frame_tick` = 1, and it holds at all other times. A pixel presented in the same cycle as a tick uses the phase from before that tick.
- R7: The effective phase is (frame phase + (row + column) mod 3) mod 3.
- R8: A fixed pixel shown over three consecutive frames lights level 2'b01 exactly once and level 2'b10 exactly twice.
- R9: Code 4'h0 gives red and green both off (black). Code 4'hF gives red and green both on (full yellow).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle pulse at the start of each internal refresh frame |
| pix_valid | input | 1 | Pixel code, row and column are valid this cycle |
| pix_code | input | 4 | Red level in [3:2], green level in [1:0] |
| pix_row | input | ROW_W (8) | Row of the pixel |
| pix_col | input | COL_W (9) | Column of the pixel |
| out_valid | output | 1 | Drive bits are valid this cycle |
| red_on | output | 1 | Red sub-pixel drive bit |
| green_on | output | 1 | Green sub-pixel drive bit |

## Verification
Every pixel result is due one clock after the cycle in which its strobe was sampled, and a frame tick changes only the pixels sampled after it. The driver changes inputs on the falling edge and adds the expected drive bits to a queue. For this it keeps its own frame phase, which it advances only after it has computed the expected bits for any pixel that shares a cycle with a tick. The monitor samples on the next falling edge, half a period after the registering edge. Each time it sees `out_valid` it takes one entry from the queue. A result that arrives with no entry waiting, or entries that are still waiting at the end of the run, count as failures.

// File: rtl/dither_pkg.sv
package dither_pkg;

    localparam int PHASE_COUNT = 3;
    localparam int LEVEL_W     = 2;
    localparam int NUM_CH      = 2;   // channel 0 = green, channel 1 = red

    typedef logic [1:0] phase_t;

    typedef enum logic [LEVEL_W-1:0] {
        LVL_OFF        = 2'b00,
        LVL_THIRD      = 2'b01,
        LVL_TWO_THIRDS = 2'b10,
        LVL_FULL       = 2'b11
    } level_e;

    typedef struct packed {
        logic valid;
        logic red;
        logic green;
    } drive_s;

    // Add two phases modulo three; both operands must be below three.
    function automatic phase_t phase_add(phase_t a, phase_t b);
        logic [2:0] sum;
        sum = {1'b0, a} + {1'b0, b};
        if (sum >= 3'(PHASE_COUNT)) begin
            sum = sum - 3'(PHASE_COUNT);
        end
        return sum[1:0];
    endfunction

endpackage

// File: rtl/frame_phase_ctr.sv
module frame_phase_ctr
    import dither_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tick,
    output phase_t phase_o
);

    phase_t phase_d, phase_q;

    always_comb begin
        phase_d = phase_q;
        if (tick) begin
            if (phase_q == phase_t'(PHASE_COUNT - 1)) begin
                phase_d = '0;
            end else begin
                phase_d = phase_q + 2'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_d;
        end
    end

    assign phase_o = phase_q;

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q < 2'(PHASE_COUNT)); // R6
    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(phase_q)); // R6
    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && phase_q == 2'd2) |=> (phase_q == 2'd0)); // R6
    AST_PHASE_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !$stable(phase_q)); // R6

endmodule

// File: rtl/pos_phase.sv
module pos_phase
    import dither_pkg::*;
#(
    parameter int ROW_W = 8,
    parameter int COL_W = 9
) (
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    output phase_t           offset_o
);

    localparam int SUM_W = ((ROW_W > COL_W) ? ROW_W : COL_W) + 1;

    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] rem;

    always_comb begin
        sum      = SUM_W'(row) + SUM_W'(col);
        rem      = sum % SUM_W'(PHASE_COUNT);
        offset_o = rem[1:0];
    end

endmodule

// File: rtl/subpix_gate.sv
module subpix_gate
    import dither_pkg::*;
(
    input  logic [LEVEL_W-1:0] level,
    input  phase_t             phase,
    output logic               lit
);

    level_e lvl;

    always_comb begin
        lvl = level_e'(level);
        unique case (lvl)
            LVL_OFF:        lit = 1'b0;
            LVL_THIRD:      lit = (phase == 2'd0);
            LVL_TWO_THIRDS: lit = (phase != 2'd2);
            LVL_FULL:       lit = 1'b1;
            default:        lit = 1'b0;
        endcase
    end

endmodule

// File: rtl/tdither_mod.sv
module tdither_mod
    import dither_pkg::*;
#(
    parameter int ROW_W = 8,
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_tick,
    input  logic             pix_valid,
    input  logic [3:0]       pix_code,
    input  logic [ROW_W-1:0] pix_row,
    input  logic [COL_W-1:0] pix_col,
    output logic             out_valid,
    output logic             red_on,
    output logic             green_on
);

    phase_t frame_phase;
    phase_t pos_offset;
    phase_t eff_phase;
    logic [NUM_CH-1:0] ch_lit;

    drive_s out_d, out_q;

    frame_phase_ctr u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (frame_tick),
        .phase_o (frame_phase)
    );

    pos_phase #(
        .ROW_W (ROW_W),
        .COL_W (COL_W)
    ) u_pos (
        .row      (pix_row),
        .col      (pix_col),
        .offset_o (pos_offset)
    );

    assign eff_phase = phase_add(frame_phase, pos_offset);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        subpix_gate u_gate (
            .level (pix_code[g*LEVEL_W +: LEVEL_W]),
            .phase (eff_phase),
            .lit   (ch_lit[g])
        );
    end

    always_comb begin
        out_d = '0;
        if (pix_valid) begin
            out_d.valid = 1'b1;
            out_d.red   = ch_lit[1];
            out_d.green = ch_lit[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid = out_q.valid;
    assign red_on    = out_q.red;
    assign green_on  = out_q.green;

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> out_valid); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !out_valid); // R2
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!red_on && !green_on)); // R2
    AST_RED_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_code[3:2] == 2'b11) |=> red_on); // R3
    AST_RED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_code[3:2] == 2'b00) |=> !red_on); // R3
    AST_GREEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_code[1:0] == 2'b11) |=> green_on); // R3
    AST_GREEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_code[1:0] == 2'b00) |=> !green_on); // R3
    AST_THIRD_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_code[3:2] == 2'b01 && eff_phase != 2'd0) |=> !red_on); // R4
    AST_TWO_THIRDS_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_code[1:0] == 2'b10 && eff_phase != 2'd2) |=> green_on); // R5
    AST_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_code == 4'h0) |=> (!red_on && !green_on)); // R9
    AST_YELLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_code == 4'hF) |=> (red_on && green_on)); // R9

endmodule

// File: tb/tdither_mod_test.sv
`timescale 1ns/1ps
module tdither_mod_test;

    localparam int ROW_W = 8;
    localparam int COL_W = 9;

    typedef struct {
        logic  red;
        logic  green;
        string tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             frame_tick = 1'b0;
    logic             pix_valid = 1'b0;
    logic [3:0]       pix_code = '0;
    logic [ROW_W-1:0] pix_row = '0;
    logic [COL_W-1:0] pix_col = '0;
    logic             out_valid, red_on, green_on;

    int total = 0;
    int bad = 0;
    int model_phase = 0;
    int r8_red = 0;
    int r8_green = 0;
    bit done = 1'b0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    tdither_mod #(.ROW_W(ROW_W), .COL_W(COL_W)) uut (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .pix_valid(pix_valid),
        .pix_code(pix_code), .pix_row(pix_row), .pix_col(pix_col),
        .out_valid(out_valid), .red_on(red_on), .green_on(green_on)
    );

    function automatic logic lit_of(logic [1:0] lvl, int ph);
        case (lvl)
            2'b00:   return 1'b0;
            2'b01:   return (ph == 0);
            2'b10:   return (ph != 2);
            default: return 1'b1;
        endcase
    endfunction

    task automatic check(string tag, int actual, int expected);
        total++;
        if (actual != expected) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    task automatic drive(logic [3:0] code, int row, int col, logic tick, string tag);
        exp_t e;
        int ph;
        @(negedge clk);
        pix_valid  = 1'b1;
        frame_tick = tick;
        pix_code   = code;
        pix_row    = ROW_W'(row);
        pix_col    = COL_W'(col);
        ph = (model_phase + ((row + col) % 3)) % 3;
        e.red   = lit_of(code[3:2], ph);
        e.green = lit_of(code[1:0], ph);
        e.tag   = tag;
        sb.push_back(e);
        if (tick) model_phase = (model_phase + 1) % 3;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pix_valid  = 1'b0;
            frame_tick = 1'b0;
        end
    endtask

    task automatic tick_only();
        @(negedge clk);
        pix_valid  = 1'b0;
        frame_tick = 1'b1;
        model_phase = (model_phase + 1) % 3;
        @(negedge clk);
        frame_tick = 1'b0;
    endtask

    // Monitor: results are registered on the rising edge, sampled on the falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check("R2 unexpected result", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check({e.tag, " red"}, int'(red_on), int'(e.red));
                    check({e.tag, " green"}, int'(green_on), int'(e.green));
                    if (e.tag == "R8") begin
                        r8_red   += int'(red_on);
                        r8_green += int'(green_on);
                    end
                end
            end else begin
                if (red_on || green_on) check("R2 drive while idle", 1, 0);
            end
        end
    end

    initial begin
        #900000;
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 out_valid in reset", int'(out_valid), 0);
        check("R1 red_on in reset", int'(red_on), 0);
        check("R1 green_on in reset", int'(green_on), 0);
        rst_n = 1'b1;
        idle(2);
        check("R1 out_valid after reset", int'(out_valid), 0);

        // R1 phase starts at zero
        drive(4'b0101, 0, 0, 1'b0, "R1");
        idle(2);

        // R3 R4 R5 R9: every code at each frame phase, origin pixel
        for (int f = 0; f < 3; f++) begin
            for (int c = 0; c < 16; c++) begin
                string t;
                if (c == 0 || c == 15) t = "R9";
                else if (c[3:2] == 2'b01 || c[1:0] == 2'b01) t = "R4";
                else if (c[3:2] == 2'b10 || c[1:0] == 2'b10) t = "R5";
                else t = "R3";
                drive(4'(c), 0, 0, 1'b0, t);
            end
            idle(1);
            tick_only();
        end
        idle(2);

        // R7 position offset at several rows and columns
        drive(4'b0110, 0, 1, 1'b0, "R7");
        drive(4'b0110, 1, 1, 1'b0, "R7");
        drive(4'b0110, 5, 7, 1'b0, "R7");
        drive(4'b1001, 239, 319, 1'b0, "R7");
        drive(4'b1001, 255, 511, 1'b0, "R7");
        drive(4'b0101, 2, 0, 1'b0, "R7");
        idle(1);
        tick_only();
        drive(4'b0110, 4, 6, 1'b0, "R7");
        drive(4'b1010, 100, 200, 1'b0, "R7");
        idle(2);

        // R6 pixel in the tick cycle uses the old phase
        drive(4'b0101, 0, 0, 1'b1, "R6");
        drive(4'b0101, 0, 0, 1'b0, "R6");
        drive(4'b1010, 0, 0, 1'b1, "R6");
        drive(4'b1010, 0, 0, 1'b0, "R6");
        idle(2);

        // R8 one pixel over three frames
        idle(1);
        r8_red = 0;
        r8_green = 0;
        for (int f = 0; f < 3; f++) begin
            drive(4'b0110, 3, 4, 1'b0, "R8");
            idle(1);
            tick_only();
        end
        idle(3);
        check("R8 red lit frames (level 01)", r8_red, 1);
        check("R8 green lit frames (level 10)", r8_green, 2);

        // R2 gaps then back-to-back, queue must drain
        idle(5);
        drive(4'hF, 9, 9, 1'b0, "R2");
        idle(3);
        drive(4'h0, 9, 9, 1'b0, "R2");
        drive(4'hF, 9, 9, 1'b0, "R2");
        idle(4);
        check("R2 pending results", sb.size(), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule